// File: doc/BRIEF.md
# Multi-Sector CHS Address Sequencer

This block keeps the cylinder/head/sector position of a multi-sector disk transfer and moves it forward one sector at a time. A configuration strobe first sets the ending-head and ending-sector limits of the drive geometry. The same strobe also stores a per-unit drive-type byte. A load strobe then presents the six start parameters of a read or write. After that, each completed sector is reported with an advance strobe. The sequencer steps the sector. It wraps the sector into the head and the head into a 16-bit cylinder, using the programmed limits. In the same cycle it decrements the remaining-sector count.

The current position is shown at the outputs as a cylinder, a head and a sector, and as a linear block address for an 18-sector, 9-head geometry. When the count runs out, a registered done flag rises. A seven-byte result block is then ready for the parameter FIFO. Inside that block the cylinder high byte is carried bit-inverted. A data access made while the count is already zero ends the transfer with an overrun status.

Top module: `chs_addr_seq`

## Requirements
- R1: While reset is asserted and in the first cycles after it, cyl, head, sector, remaining, lba, end_status and done are all 0. With a drive-type byte of 0, polling is 1.
- R2: A load (ld_we) sets the head, sector, count and physical head from their ports. It sets the cylinder to {~ld_cyl_hi_n, ld_cyl_lo}, clears done and sets end_status to 0x00. All of these are visible one cycle later.
- R3: On each accepted advance the sector increments by 1. If the sector was already greater than or equal to the ending-sector limit, it becomes 0 instead.
- R4: When the sector wraps, the head increments by 1. If the head was already greater than or equal to the ending-head limit, the head becomes 0 and the 16-bit cylinder increments. A low byte of 0xFF rolls to 0 and carries into the high byte.
- R5: A specify strobe latches the ending-head and ending-sector limits. It also stores spec_type for unit spec_unit. polling is 1 when bit 0 of the stored type byte of unit unit_sel is 0. Without the strobe, the limits do not change.
- R6: Each accepted advance decrements remaining by 1. When it reaches 0, done rises with end_status 0x00. After that, advances and accesses change nothing until the next load.
- R7: An advance or data access made while a transfer is active with remaining equal to 0 ends the transfer. done rises and end_status becomes 0x02 (overrun).
- R8: lba equals 162·cyl + 18·head + sector at all times.
- R9: result holds seven bytes, with byte k at bits [8k+7:8k]. In order they are: end_status, physical head, ~cyl[15:8], cyl[7:0], head, sector, remaining.
- R10: A load while done is high clears done and starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec_we | input | 1 | Specify strobe |
| spec_unit | input | UNIT_W | Unit whose drive-type byte is written |
| spec_type | input | 8 | Drive-type byte (bit 0 = interrupt mode, 0 means polling) |
| spec_end_head | input | 8 | Ending-head limit |
| spec_end_sec | input | 8 | Ending-sector limit |
| unit_sel | input | UNIT_W | Unit whose polling mode is reported |
| polling | output | 1 | Selected unit is in polling mode |
| ld_we | input | 1 | Load start parameters |
| ld_phys_head | input | 8 | Physical head |
| ld_cyl_hi_n | input | 8 | Cylinder high byte, inverted |
| ld_cyl_lo | input | 8 | Cylinder low byte |
| ld_head | input | 8 | Logical head |
| ld_sector | input | 8 | Logical sector |
| ld_count | input | 8 | Sectors to transfer |
| sec_adv | input | 1 | One sector completed |
| data_acc | input | 1 | Data access strobe |
| cyl | output | 16 | Current cylinder |
| head | output | 8 | Current head |
| sector | output | 8 | Current sector |
| remaining | output | 8 | Remaining sector count |
| lba | output | LBA_W | Linear block address |
| done | output | 1 | Transfer ended (registered) |
| end_status | output | 8 | End status: 0x00 normal, 0x02 overrun |
| result | output | 56 | Seven-byte result block |

## Verification
The bench sweeps several ending limits, including 0, which makes the sector or head wrap on every step. Start positions are placed just before a wrap, with a cylinder low byte of 0xFF. A design that compared with strict equality instead of "at or above" would run past a limit that was set lower than the start position. A design without the byte carry would jump back to cylinder 0. The bench also checks that the high byte stays inverted in the result block. It confirms that advances after done leave the position frozen. A zero-count load followed by an access must report overrun rather than wrap the count to 255.

// File: rtl/chs_seq_pkg.sv
package chs_seq_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t ST_OK      = 8'h00;
  localparam byte_t ST_OVERRUN = 8'h02;
  typedef struct packed {
    logic [15:0] cyl;
    byte_t       head;
    byte_t       sec;
  } chs_t;
endpackage

// File: rtl/chs_limit_regs.sv
module chs_limit_regs
  import chs_seq_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2,
  parameter int POLL_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spec_we,
  input  logic [UNIT_W-1:0] spec_unit,
  input  byte_t             spec_type,
  input  byte_t             spec_end_head,
  input  byte_t             spec_end_sec,
  input  logic [UNIT_W-1:0] unit_sel,
  output byte_t             end_head,
  output byte_t             end_sec,
  output logic              polling
);
  byte_t lim_head_q, lim_sec_q;
  byte_t type_q [NUM_UNITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_head_q <= '0;
      lim_sec_q  <= '0;
    end else if (spec_we) begin
      lim_head_q <= spec_end_head;
      lim_sec_q  <= spec_end_sec;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic wr_en;
    assign wr_en = spec_we && (spec_unit == UNIT_W'(u));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     type_q[u] <= '0;
      else if (wr_en) type_q[u] <= spec_type;
    end
  end

  assign end_head = lim_head_q;
  assign end_sec  = lim_sec_q;
  assign polling  = ~type_q[unit_sel][POLL_BIT];

  p_limit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_we |=> $stable(lim_head_q) && $stable(lim_sec_q));
endmodule

// File: rtl/chs_stepper.sv
module chs_stepper
  import chs_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t ld_phys_head,
  input  byte_t ld_cyl_hi_n,
  input  byte_t ld_cyl_lo,
  input  byte_t ld_head,
  input  byte_t ld_sector,
  input  byte_t ld_count,
  input  logic  adv,
  input  logic  acc,
  input  byte_t end_head,
  input  byte_t end_sec,
  output chs_t  pos,
  output byte_t phys_head,
  output byte_t count,
  output logic  done,
  output byte_t status
);
  chs_t  pos_q,  pos_d;
  byte_t phys_q, phys_d, cnt_q, cnt_d, st_q, st_d;
  logic  act_q,  act_d, done_q, done_d;
  logic  sec_wrap, head_wrap;

  assign sec_wrap  = pos_q.sec  >= end_sec;
  assign head_wrap = pos_q.head >= end_head;

  always_comb begin
    pos_d  = pos_q;
    phys_d = phys_q;
    cnt_d  = cnt_q;
    st_d   = st_q;
    act_d  = act_q;
    done_d = done_q;
    if (load) begin
      pos_d.cyl  = {~ld_cyl_hi_n, ld_cyl_lo};
      pos_d.head = ld_head;
      pos_d.sec  = ld_sector;
      phys_d     = ld_phys_head;
      cnt_d      = ld_count;
      st_d       = ST_OK;
      act_d      = 1'b1;
      done_d     = 1'b0;
    end else if (act_q && (adv || acc) && cnt_q == 8'd0) begin
      st_d   = ST_OVERRUN;
      act_d  = 1'b0;
      done_d = 1'b1;
    end else if (act_q && adv) begin
      if (!sec_wrap) begin
        pos_d.sec = pos_q.sec + 8'd1;
      end else begin
        pos_d.sec = 8'd0;
        if (!head_wrap) begin
          pos_d.head = pos_q.head + 8'd1;
        end else begin
          pos_d.head = 8'd0;
          pos_d.cyl  = pos_q.cyl + 16'd1;
        end
      end
      cnt_d = cnt_q - 8'd1;
      if (cnt_q == 8'd1) begin
        st_d   = ST_OK;
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      phys_q <= '0;
      cnt_q  <= '0;
      st_q   <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      phys_q <= phys_d;
      cnt_q  <= cnt_d;
      st_q   <= st_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign pos       = pos_q;
  assign phys_head = phys_q;
  assign count     = cnt_q;
  assign done      = done_q;
  assign status    = st_q;

  p_sector_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && adv && !load && cnt_q != 8'd0 |=>
      (pos_q.sec == 8'd0) || (pos_q.sec == $past(pos_q.sec) + 8'd1));
  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && adv && !load && cnt_q != 8'd0 && pos_q.sec < end_sec |=>
      $stable(pos_q.head) && $stable(pos_q.cyl));
  p_count_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && adv && !load && cnt_q != 8'd0 |=> cnt_q == $past(cnt_q) - 8'd1);
  p_done_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !load |=> $stable(pos_q) && $stable(cnt_q) && done_q);
  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && (adv || acc) && !load && cnt_q == 8'd0 |=>
      done_q && st_q == ST_OVERRUN);
  p_load_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done_q);
endmodule

// File: rtl/chs_lba_calc.sv
module chs_lba_calc
  import chs_seq_pkg::*;
#(
  parameter int SPT   = 18,
  parameter int HEADS = 9,
  parameter int LBA_W = 24
) (
  input  chs_t             pos,
  output logic [LBA_W-1:0] lba
);
  localparam int CYL_MUL = SPT * HEADS;
  assign lba = LBA_W'(pos.cyl)  * LBA_W'(CYL_MUL)
             + LBA_W'(pos.head) * LBA_W'(SPT)
             + LBA_W'(pos.sec);
endmodule

// File: rtl/chs_addr_seq.sv
module chs_addr_seq
  import chs_seq_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = $clog2(NUM_UNITS),
  parameter int SPT       = 18,
  parameter int HEADS     = 9,
  parameter int LBA_W     = $clog2(SPT * HEADS * 65536)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spec_we,
  input  logic [UNIT_W-1:0] spec_unit,
  input  logic [7:0]        spec_type,
  input  logic [7:0]        spec_end_head,
  input  logic [7:0]        spec_end_sec,
  input  logic [UNIT_W-1:0] unit_sel,
  output logic              polling,
  input  logic              ld_we,
  input  logic [7:0]        ld_phys_head,
  input  logic [7:0]        ld_cyl_hi_n,
  input  logic [7:0]        ld_cyl_lo,
  input  logic [7:0]        ld_head,
  input  logic [7:0]        ld_sector,
  input  logic [7:0]        ld_count,
  input  logic              sec_adv,
  input  logic              data_acc,
  output logic [15:0]       cyl,
  output logic [7:0]        head,
  output logic [7:0]        sector,
  output logic [7:0]        remaining,
  output logic [LBA_W-1:0]  lba,
  output logic              done,
  output logic [7:0]        end_status,
  output logic [55:0]       result
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  byte_t      end_head, end_sec, phys;
  chs_t       pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  chs_limit_regs #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .POLL_BIT(0)) limits_i (
    .clk(clk), .rst_n(rst_int_n), .spec_we(spec_we), .spec_unit(spec_unit),
    .spec_type(spec_type), .spec_end_head(spec_end_head),
    .spec_end_sec(spec_end_sec), .unit_sel(unit_sel),
    .end_head(end_head), .end_sec(end_sec), .polling(polling)
  );

  chs_stepper stepper_i (
    .clk(clk), .rst_n(rst_int_n), .load(ld_we),
    .ld_phys_head(ld_phys_head), .ld_cyl_hi_n(ld_cyl_hi_n),
    .ld_cyl_lo(ld_cyl_lo), .ld_head(ld_head), .ld_sector(ld_sector),
    .ld_count(ld_count), .adv(sec_adv), .acc(data_acc),
    .end_head(end_head), .end_sec(end_sec), .pos(pos), .phys_head(phys),
    .count(remaining), .done(done), .status(end_status)
  );

  chs_lba_calc #(.SPT(SPT), .HEADS(HEADS), .LBA_W(LBA_W)) lba_i (
    .pos(pos), .lba(lba)
  );

  assign cyl    = pos.cyl;
  assign head   = pos.head;
  assign sector = pos.sec;
  assign result = {remaining, pos.sec, pos.head, pos.cyl[7:0],
                   ~pos.cyl[15:8], phys, end_status};

  p_result_cyl_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ld_we |=> result[23:16] == $past(ld_cyl_hi_n));
endmodule

// File: tb/chs_addr_seq_tb_top.sv
`timescale 1ns/1ps
module chs_addr_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, spec_we, ld_we, sec_adv, data_acc, polling, done;
  logic [1:0] spec_unit, unit_sel;
  logic [7:0] spec_type, spec_end_head, spec_end_sec;
  logic [7:0] ld_phys_head, ld_cyl_hi_n, ld_cyl_lo, ld_head, ld_sector, ld_count;
  logic [15:0] cyl;
  logic [7:0] head, sector, remaining, end_status;
  logic [23:0] lba;
  logic [55:0] result;

  chs_addr_seq dut_i (.*);

  int errors = 0, checks = 0;
  int m_eh, m_es, m_cyl, m_head, m_sec, m_cnt, m_phys, m_st;
  bit m_done, m_act;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    longint exp_res;
    chk({tag, " cyl"}, cyl, m_cyl);
    chk({tag, " head"}, head, m_head);
    chk({tag, " sector"}, sector, m_sec);
    chk({tag, " remaining"}, remaining, m_cnt);
    chk({tag, " done"}, done, m_done);
    chk({tag, " status"}, end_status, m_st);
    chk("R8 lba", lba, 162 * m_cyl + 18 * m_head + m_sec);
    exp_res = longint'(m_st) | (longint'(m_phys) << 8)
            | (longint'((~(m_cyl >> 8)) & 255) << 16)
            | (longint'(m_cyl & 255) << 24) | (longint'(m_head) << 32)
            | (longint'(m_sec) << 40) | (longint'(m_cnt) << 48);
    chk("R9 result", result, exp_res);
  endtask

  task automatic do_spec(input int u, input int t, input int eh, input int es);
    spec_we = 1; spec_unit = 2'(u); spec_type = 8'(t);
    spec_end_head = 8'(eh); spec_end_sec = 8'(es);
    @(negedge clk);
    spec_we = 0;
    m_eh = eh; m_es = es;
  endtask

  task automatic do_load(input int ph, input int c, input int h, input int s, input int n);
    ld_we = 1; ld_phys_head = 8'(ph); ld_cyl_hi_n = ~8'(c >> 8);
    ld_cyl_lo = 8'(c); ld_head = 8'(h); ld_sector = 8'(s); ld_count = 8'(n);
    @(negedge clk);
    ld_we = 0;
    m_phys = ph; m_cyl = c; m_head = h; m_sec = s; m_cnt = n;
    m_st = 0; m_done = 0; m_act = 1;
    chk_all("R2 load");
  endtask

  task automatic do_strobe(input bit a, input bit d, input string tag);
    sec_adv = a; data_acc = d;
    @(negedge clk);
    sec_adv = 0; data_acc = 0;
    if (m_act && m_cnt == 0) begin
      m_st = 2; m_done = 1; m_act = 0;
    end else if (m_act && a) begin
      if (m_sec >= m_es) begin
        m_sec = 0;
        if (m_head >= m_eh) begin
          m_head = 0; m_cyl = (m_cyl + 1) & 16'hffff;
        end else m_head++;
      end else m_sec++;
      m_cnt--;
      if (m_cnt == 0) begin m_done = 1; m_st = 0; m_act = 0; end
    end
    chk_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ehs[3] = '{0, 1, 8};
    int ess[4] = '{0, 1, 5, 17};
    rst_n = 0; spec_we = 0; ld_we = 0; sec_adv = 0; data_acc = 0;
    spec_unit = 0; unit_sel = 0; spec_type = 0; spec_end_head = 0; spec_end_sec = 0;
    ld_phys_head = 0; ld_cyl_hi_n = 0; ld_cyl_lo = 0; ld_head = 0; ld_sector = 0; ld_count = 0;
    m_cyl = 0; m_head = 0; m_sec = 0; m_cnt = 0; m_phys = 0; m_st = 0; m_done = 0; m_act = 0;
    m_eh = 0; m_es = 0;
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    chk("R1 polling", polling, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_all("R1 after release");

    // R5: per-unit drive type, polling when bit 0 is 0
    do_spec(1, 8'h01, 8, 17);
    do_spec(2, 8'hFE, 8, 17);
    unit_sel = 1; #0.1; chk("R5 unit1 interrupt mode", polling, 0);
    unit_sel = 2; #0.1; chk("R5 unit2 polling", polling, 1);
    unit_sel = 0; #0.1; chk("R5 unit0 untouched", polling, 1);

    // R3 R4 sweep over limits and start points
    foreach (ehs[i]) foreach (ess[j]) begin
      do_spec(0, 0, ehs[i], ess[j]);
      do_load(3, 16'h00FF, ehs[i], ess[j], 30);
      for (int k = 0; k < 30; k++) do_strobe(1, 0, "R3 R4 step");
      do_strobe(1, 0, "R6 ignored after done");
      do_strobe(0, 1, "R6 access after done");
      do_load(7, 16'h12FF, 0, 0, 20);
      for (int k = 0; k < 20; k++) do_strobe(1, 0, "R4 carry sweep");
    end

    // R4: full 16-bit wrap through 0xFFFF, start above limits
    do_spec(0, 0, 2, 3);
    do_load(1, 16'hFFFF, 5, 9, 3);
    do_strobe(1, 0, "R4 above-limit wrap");
    do_strobe(1, 0, "R4 step");
    do_strobe(1, 0, "R6 final");
    chk("R6 done raised", done, 1);

    // R7 overrun on zero-count load
    do_load(2, 16'h0100, 1, 1, 0);
    do_strobe(0, 1, "R7 overrun access");
    chk("R7 status", end_status, 8'h02);
    do_load(2, 16'h0100, 1, 1, 0);
    do_strobe(1, 0, "R7 overrun advance");

    // R10 load while done
    do_load(4, 16'h0042, 0, 0, 2);
    chk("R10 done cleared", done, 0);

    // R5 limits hold without strobe
    spec_end_head = 0; spec_end_sec = 0;
    @(negedge clk);
    do_strobe(1, 0, "R5 limits held");
    do_strobe(1, 0, "R5 limits held 2");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule